// File: doc/BRIEF.md
# PHY Management Interrupt Register Unit

This block is the interrupt slice of an Ethernet transceiver's management register file. Internal PHY logic gives it single-cycle event pulses and, for each source, a live level. Each pulse sets a sticky flag. A mask register enables each source. The block drives an active-low interrupt pin whenever an enabled source needs attention.

Software reaches the block through a plain register port. The port carries a 5-bit address, a read strobe, a write strobe, 16-bit write data and combinational 16-bit read data. It serves the flag register (29), the mask register (30), the special control/status register (31), the done bit in register 1 and the interrupt-mode bit in register 17.

The mode bit chooses how the pin releases:
- **Primary mode** (bit 6 of register 17 = 0): the pin follows the latched flags, so it releases only after register 29 has been read.
- **Alternative mode** (bit 6 of register 17 = 1): the pin follows the live source levels.

The register port is a control path with no back-pressure. Every strobe takes effect in the cycle it is seen. `rd_data` is valid in that same cycle and is zero when no read is strobed.

Top module: `phy_irq_unit`

## Requirements
- R1: After reset, the following hold: register 30 reads 0x0000, register 17 reads 0x0000, register 29 and register 1 read 0x0000, register 31 reads 0x0040 with the speed code in bits 4:2, and `irq_n` is 1.
- R2: A pulse on `evt_pulse[k]` sets bit k of register 29, with k from 1 to 7. Bit 0 and bits 15:8 of register 29 always read 0, and writes to register 29 have no effect.
- R3: A read of register 29 returns the flags and clears them at that clock edge. A pulse that arrives in the same cycle as the read stays set for the next read.
- R4: Bits 7:1 of register 30 are read/write mask bits, with 1 meaning enabled. Bits 15:8 and bit 0 of register 30 read 0 whatever is written.
- R5: In primary mode, `irq_n` is 0 while any flag has its mask bit set. It stays 0 after the source level drops and returns to 1 in the cycle after a read of register 29 leaves no enabled flag set.
- R6: A flag whose mask bit is 0 does not pull `irq_n` low. Setting the mask bit later, while the flag is still latched, pulls `irq_n` low.
- R7: In alternative mode, `irq_n` is the inverse of the OR of `src_lvl & mask`. Latched flags have no effect on the pin, and no read is needed to release it.
- R8: A pulse on `an_done` latches a done bit. It reads as bit 5 of register 1, and reading register 1 clears it. Bit 12 of register 31 shows the same bit, and reading register 31 does not clear it.
- R9: Register 31 bits 4:2 read `spd_dpx` (001 = 10M half, 101 = 10M full, 010 = 100M half, 110 = 100M full). Bit 6 is writable and resets to 1, and drives `enc_en`. Bit 0 is writable and resets to 0, and drives `scr_dis`. All other bits of register 31 read 0.
- R10: Reads of any address other than 1, 17, 29, 30 and 31 return 0, and writes to them change no register.
- R11: Every reset forces bit 6 of register 17 back to 0 (primary mode), even if alternative mode was selected before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 7 | One-cycle event pulses; element k maps to flag bit k |
| src_lvl | input | 7 | Live source conditions used in alternative mode |
| an_done | input | 1 | Auto-negotiation completion pulse |
| spd_dpx | input | 3 | Resolved speed/duplex code |
| reg_addr | input | 5 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid in the cycle of `rd_en` |
| irq_n | output | 1 | Active-low interrupt |
| enc_en | output | 1 | 4B5B encoder/decoder enable |
| scr_dis | output | 1 | Scrambler disable |

## Verification
A flag that fails to stick or to clear shows up in the very next read of register 29, and in primary mode it also shows on `irq_n` one cycle after the event or the clearing read. A wrong mask or mode bit shows on `irq_n` in the same cycle, because the pin is a combinational function of that state and the live levels. A done bit that is cleared by the wrong read shows up at the next read of register 1 or register 31. Corruption caused by writes to other addresses shows up when the held registers are read back.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'd1;
  localparam logic [ADDR_W-1:0] A_MODE  = 5'd17;
  localparam logic [ADDR_W-1:0] A_FLAGS = 5'd29;
  localparam logic [ADDR_W-1:0] A_MASK  = 5'd30;
  localparam logic [ADDR_W-1:0] A_SPCS  = 5'd31;
  localparam int MODE_BIT   = 6;
  localparam int DONE_BIT   = 5;
  localparam int SPCS_DONE  = 12;
  localparam int SPCS_ENC   = 6;
  localparam int SPCS_SCR   = 0;
  localparam int SPCS_SPD_L = 2;
endpackage

// File: rtl/phy_irq_latch.sv
module phy_irq_latch #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)     q_o[k] <= 1'b0;
      else if (clr_i) q_o[k] <= set_i[k];
      else            q_o[k] <= q_o[k] | set_i[k];
    end
  end
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
#(
  parameter int NUM_SRC = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_SRC:1]  mask_o,
  output logic              alt_mode_o,
  output logic              enc_en_o,
  output logic              scr_dis_o
);
  logic unused_wdata;
  assign unused_wdata = ^{wdata[DATA_W-1:NUM_SRC+1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o     <= '0;
      alt_mode_o <= 1'b0;
      enc_en_o   <= 1'b1;
      scr_dis_o  <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_MASK: mask_o     <= wdata[NUM_SRC:1];
        A_MODE: alt_mode_o <= wdata[MODE_BIT];
        A_SPCS: begin
          enc_en_o  <= wdata[SPCS_ENC];
          scr_dis_o <= wdata[SPCS_SCR];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/phy_irq_rdmux.sv
module phy_irq_rdmux
  import phy_irq_pkg::*;
#(
  parameter int NUM_SRC = 7
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_SRC:1]  flags,
  input  logic [NUM_SRC:1]  mask,
  input  logic              alt_mode,
  input  logic              done,
  input  logic [2:0]        spd,
  input  logic              enc_en,
  input  logic              scr_dis,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_STAT:  rdata[DONE_BIT] = done;
        A_MODE:  rdata[MODE_BIT] = alt_mode;
        A_FLAGS: rdata[NUM_SRC:1] = flags;
        A_MASK:  rdata[NUM_SRC:1] = mask;
        A_SPCS: begin
          rdata[SPCS_DONE]                 = done;
          rdata[SPCS_ENC]                  = enc_en;
          rdata[SPCS_SPD_L+2:SPCS_SPD_L]   = spd;
          rdata[SPCS_SCR]                  = scr_dis;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/phy_irq_unit.sv
module phy_irq_unit
  import phy_irq_pkg::*;
#(
  parameter int NUM_SRC = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC:1]  evt_pulse,
  input  logic [NUM_SRC:1]  src_lvl,
  input  logic              an_done,
  input  logic [2:0]        spd_dpx,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n,
  output logic              enc_en,
  output logic              scr_dis
);
  logic [NUM_SRC:1] flag_q;
  logic [NUM_SRC:1] mask_q;
  logic             alt_mode_q;
  logic             done_q;
  logic             flag_rd;
  logic             stat_rd;
  logic             prim_req;
  logic             alt_req;

  assign flag_rd = rd_en && (reg_addr == A_FLAGS);
  assign stat_rd = rd_en && (reg_addr == A_STAT);

  phy_irq_latch #(.W(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(evt_pulse), .clr_i(flag_rd), .q_o(flag_q)
  );

  phy_irq_latch #(.W(1)) u_done (
    .clk(clk), .rst_n(rst_n), .set_i(an_done), .clr_i(stat_rd), .q_o(done_q)
  );

  phy_irq_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_addr), .wdata(wr_data),
    .mask_o(mask_q), .alt_mode_o(alt_mode_q), .enc_en_o(enc_en), .scr_dis_o(scr_dis)
  );

  phy_irq_rdmux #(.NUM_SRC(NUM_SRC)) u_rdmux (
    .rd_en(rd_en), .addr(reg_addr), .flags(flag_q), .mask(mask_q),
    .alt_mode(alt_mode_q), .done(done_q), .spd(spd_dpx), .enc_en(enc_en),
    .scr_dis(scr_dis), .rdata(rd_data)
  );

  assign prim_req = |(flag_q & mask_q);
  assign alt_req  = |(src_lvl & mask_q);
  assign irq_n    = ~(alt_mode_q ? alt_req : prim_req);
endmodule

// File: rtl/phy_irq_checker.sv
module phy_irq_checker
  import phy_irq_pkg::*;
#(
  parameter int NUM_SRC = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_SRC:1]  evt_pulse,
  input logic [NUM_SRC:1]  src_lvl,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_n,
  input logic [NUM_SRC:1]  flag_q,
  input logic [NUM_SRC:1]  mask_q,
  input logic              alt_mode_q,
  input logic              done_q
);
  logic rd29;
  assign rd29 = rd_en && (reg_addr == A_FLAGS);

  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((flag_q & $past(evt_pulse)) == $past(evt_pulse)));

  p_clear_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd29 |=> (flag_q == $past(evt_pulse)));

  p_rsv_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (reg_addr == A_FLAGS || reg_addr == A_MASK)) |->
      (rd_data[0] == 1'b0 && (rd_data >> (NUM_SRC + 1)) == '0));

  p_prim_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_mode_q && !irq_n && !rd29 && !wr_en) |=> !irq_n);

  p_prim_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_mode_q && rd29 && evt_pulse == '0 && !wr_en) |=> irq_n);

  p_alt_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_mode_q && |(src_lvl & mask_q)) |-> !irq_n);

  p_done_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && rd_en && reg_addr == A_SPCS) |=> done_q);

  p_unimpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr != A_STAT && reg_addr != A_MODE && reg_addr != A_FLAGS &&
     reg_addr != A_MASK && reg_addr != A_SPCS) |-> rd_data == '0);
endmodule

bind phy_irq_unit phy_irq_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .src_lvl(src_lvl),
  .reg_addr(reg_addr), .rd_en(rd_en), .wr_en(wr_en), .rd_data(rd_data),
  .irq_n(irq_n), .flag_q(flag_q), .mask_q(mask_q), .alt_mode_q(alt_mode_q),
  .done_q(done_q)
);

// File: tb/phy_irq_unit_bench.sv
module phy_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:1]  evt_pulse = '0;
  logic [7:1]  src_lvl = '0;
  logic        an_done = 1'b0;
  logic [2:0]  spd_dpx = 3'b101;
  logic [4:0]  reg_addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq_n;
  logic        enc_en;
  logic        scr_dis;

  int vecs = 0;
  int errs = 0;
  bit done_run = 0;

  always #2 clk = ~clk;

  phy_irq_unit u_phy_irq_unit (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .src_lvl(src_lvl),
    .an_done(an_done), .spd_dpx(spd_dpx), .reg_addr(reg_addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n),
    .enc_en(enc_en), .scr_dis(scr_dis)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
  endtask

  task automatic pulse(input logic [7:1] e);
    @(negedge clk);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 irq_n", {15'd0, irq_n}, 16'd1);
    rd(5'd30, d); chk("R1 reg30", d, 16'h0000);
    rd(5'd17, d); chk("R1 reg17", d, 16'h0000);
    rd(5'd29, d); chk("R1 reg29", d, 16'h0000);
    rd(5'd1, d);  chk("R1 reg1", d, 16'h0000);
    rd(5'd31, d); chk("R1 reg31", d, 16'h0054);
    chk("R1 enc_en", {15'd0, enc_en}, 16'd1);
  endtask

  task automatic t_flags();
    logic [15:0] d;
    pulse(7'b0010001);
    wr(5'd29, 16'hFFFF);
    rd(5'd29, d); chk("R2 flags latched", d, 16'h0022);
    chk("R6 masked flag no irq", {15'd0, irq_n}, 16'd1);
    rd(5'd29, d); chk("R3 cleared by read", d, 16'h0000);
  endtask

  task automatic t_race();
    logic [15:0] d;
    pulse(7'b0000100);
    @(negedge clk);
    reg_addr = 5'd29; rd_en = 1'b1; evt_pulse = 7'b0000010;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; evt_pulse = '0;
    chk("R3 read during event", d, 16'h0008);
    rd(5'd29, d); chk("R3 event kept", d, 16'h0004);
    rd(5'd29, d); chk("R3 then clear", d, 16'h0000);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wr(5'd30, 16'hFFFF);
    rd(5'd30, d); chk("R4 mask rw/rsv", d, 16'h00FE);
    wr(5'd30, 16'h0000);
    rd(5'd30, d); chk("R4 mask cleared", d, 16'h0000);
  endtask

  task automatic t_primary();
    logic [15:0] d;
    wr(5'd30, 16'h00FE);
    @(negedge clk);
    src_lvl = 7'b0001000; evt_pulse = 7'b0001000;
    @(negedge clk);
    evt_pulse = '0;
    #1 chk("R5 irq asserted", {15'd0, irq_n}, 16'd0);
    src_lvl = '0;
    repeat (3) @(negedge clk);
    #1 chk("R5 irq held after level drop", {15'd0, irq_n}, 16'd0);
    rd(5'd29, d); chk("R5 flag read", d, 16'h0010);
    chk("R5 irq released after read", {15'd0, irq_n}, 16'd1);
  endtask

  task automatic t_late_mask();
    logic [15:0] d;
    wr(5'd30, 16'h0000);
    pulse(7'b1000000);
    chk("R6 unmasked no irq", {15'd0, irq_n}, 16'd1);
    wr(5'd30, 16'h0080);
    chk("R6 mask set later asserts", {15'd0, irq_n}, 16'd0);
    rd(5'd29, d); chk("R6 flag value", d, 16'h0080);
    chk("R6 released", {15'd0, irq_n}, 16'd1);
  endtask

  task automatic t_alt();
    logic [15:0] d;
    wr(5'd30, 16'h00FE);
    wr(5'd17, 16'hFFFF);
    rd(5'd17, d); chk("R7 mode bit", d, 16'h0040);
    pulse(7'b0000100);
    chk("R7 latched flag ignored", {15'd0, irq_n}, 16'd1);
    @(negedge clk);
    src_lvl = 7'b0000010;
    #1 chk("R7 live level asserts", {15'd0, irq_n}, 16'd0);
    @(negedge clk);
    src_lvl = '0;
    #1 chk("R7 releases without read", {15'd0, irq_n}, 16'd1);
    rd(5'd29, d); chk("R7 flags still latched", d, 16'h0008);
  endtask

  task automatic t_done();
    logic [15:0] d;
    @(negedge clk); an_done = 1'b1;
    @(negedge clk); an_done = 1'b0;
    rd(5'd31, d); chk("R8 reg31 done", d, 16'h1054);
    rd(5'd31, d); chk("R8 reg31 no clear", d, 16'h1054);
    rd(5'd1, d);  chk("R8 reg1 done", d, 16'h0020);
    rd(5'd1, d);  chk("R8 reg1 cleared", d, 16'h0000);
    rd(5'd31, d); chk("R8 reg31 after clear", d, 16'h0054);
  endtask

  task automatic t_ctrl();
    logic [15:0] d;
    wr(5'd31, 16'hFFFF);
    rd(5'd31, d); chk("R9 ctrl set", d, 16'h0055);
    chk("R9 scr_dis", {15'd0, scr_dis}, 16'd1);
    wr(5'd31, 16'h0000);
    spd_dpx = 3'b110;
    #1;
    rd(5'd31, d); chk("R9 ctrl clr, 100 full", d, 16'h0018);
    chk("R9 enc_en", {15'd0, enc_en}, 16'd0);
    spd_dpx = 3'b010;
    #1;
    rd(5'd31, d); chk("R9 100 half", d, 16'h0008);
    wr(5'd31, 16'h0040);
    spd_dpx = 3'b101;
  endtask

  task automatic t_unimpl();
    logic [15:0] d;
    wr(5'd30, 16'h0006);
    wr(5'd5, 16'hFFFF);
    wr(5'd16, 16'hFFFF);
    wr(5'd28, 16'hFFFF);
    rd(5'd5, d);  chk("R10 unimpl read", d, 16'h0000);
    rd(5'd0, d);  chk("R10 unimpl read 0", d, 16'h0000);
    rd(5'd30, d); chk("R10 mask untouched", d, 16'h0006);
    rd(5'd17, d); chk("R10 mode untouched", d, 16'h0040);
    rd(5'd31, d); chk("R10 reg31 untouched", d, 16'h0054);
  endtask

  task automatic t_rereset();
    logic [15:0] d;
    do_reset();
    rd(5'd17, d); chk("R11 mode forced primary", d, 16'h0000);
    rd(5'd30, d); chk("R11 mask reset", d, 16'h0000);
  endtask

  initial begin
    #2_000_000;
    if (!done_run) begin
      errs++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_flags();
    t_race();
    t_mask();
    t_primary();
    t_late_mask();
    t_alt();
    t_done();
    t_ctrl();
    t_unimpl();
    t_rereset();
    done_run = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule